// File: doc/BRIEF.md
# PS/2 Mouse Movement Packet Decoder

This block listens to the two-wire serial link of a PS/2 mouse and turns each three-byte movement report into parallel fields. The clock and data lines are brought into the system clock domain through a short synchronizer. Each falling edge of the serial clock samples one bit. Eleven bits form one word, and three good words form one report. The first word is the status byte, the second the X byte and the third the Y byte.

When the third word arrives intact, the block raises a single-cycle valid strobe. In the same cycle it updates the outputs: both button states, two 9-bit two's-complement movement values and both overflow flags. Those outputs then hold their values until the next report. A damaged word, a misaligned status byte or a stalled link sends the packet assembler back to waiting for a status byte, so the block recovers on its own.

Top module: `ps2_mouse_decoder`

## Requirements
- R1: While reset is held, and right after it, `pkt_valid` and `pkt_err` are 0 and every decoded field is 0.
- R2: Each complete report of three good words produces exactly one `pkt_valid` pulse, one system clock wide.
- R3: `btn_left` takes status bit 0 and `btn_right` takes status bit 1. A value of 1 means the button is pressed.
- R4: `move_x` is {status bit 4, X byte} and `move_y` is {status bit 5, Y byte}, read as 9-bit two's complement. Positive X means rightward motion and positive Y means upward motion.
- R5: `ovf_x` takes status bit 6 and `ovf_y` takes status bit 7.
- R6: A word expected as status whose data bit 3 is 0 is dropped without any error, and the next word is again taken as status.
- R7: A word whose parity bit does not make the count of ones across the data and parity bits odd raises `pkt_err` for one cycle. It also discards the partial packet, and the next good word is taken as status.
- R8: A word whose first bit is 1 or whose eleventh bit is 0 is handled the same way as a parity error.
- R9: If GAP_CYCLES system clocks pass with no falling serial clock edge, both the bit count and the byte count return to zero. A partly received word or packet is then lost.
- R10: The decoded fields change only in the cycle where `pkt_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk | input | 1 | Serial clock from the mouse, idles high |
| ps2_dat | input | 1 | Serial data from the mouse, idles high |
| pkt_valid | output | 1 | One-cycle strobe when a report is decoded |
| btn_left | output | 1 | Left button pressed |
| btn_right | output | 1 | Right button pressed |
| move_x | output | 9 | Signed X movement |
| move_y | output | 9 | Signed Y movement |
| ovf_x | output | 1 | X movement overflow |
| ovf_y | output | 1 | Y movement overflow |
| pkt_err | output | 1 | One-cycle strobe on a parity or framing error |

## Verification
The assertions assume the serial clock is much slower than the system clock. This means every report spans far more system cycles than two, so a valid or error strobe can never fall in back-to-back cycles. The stimulus keeps each serial clock half period at several system cycles and changes data only while the serial clock is high. Within a packet, the gap between words stays well under GAP_CYCLES. Idle pauses between test cases are deliberately made longer than the timeout, so that each case starts from an aligned state.

// File: rtl/ps2_mouse_decoder.sv
module ps2_mouse_decoder #(
  parameter int GAP_CYCLES  = 200000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk,
  input  logic       ps2_dat,
  output logic       pkt_valid,
  output logic       btn_left,
  output logic       btn_right,
  output logic [8:0] move_x,
  output logic [8:0] move_y,
  output logic       ovf_x,
  output logic       ovf_y,
  output logic       pkt_err
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [GW-1:0] GAP_LIM = GW'(GAP_CYCLES);
  localparam logic [3:0] LAST_BIT = 4'd10;

  logic [SYNC_STAGES:0]   ck_q;
  logic [SYNC_STAGES-1:0] dt_q;
  logic [GW-1:0] gap;
  logic [3:0]    bit_cnt;
  logic [9:0]    sh;
  logic [1:0]    byte_cnt;
  logic [7:0]    stat_q, x_q;

  wire        fall      = ck_q[SYNC_STAGES] & ~ck_q[SYNC_STAGES-1];
  wire        dat       = dt_q[SYNC_STAGES-1];
  wire [10:0] word      = {dat, sh};
  wire [7:0]  data      = word[8:1];
  wire        word_done = fall && (bit_cnt == LAST_BIT);
  wire        word_ok   = !word[0] && word[10] && (^word[9:1]);
  wire        stale     = (gap == GAP_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '1;
      dt_q <= '1;
    end else begin
      ck_q <= {ck_q[SYNC_STAGES-1:0], ps2_clk};
      dt_q <= {dt_q[SYNC_STAGES-2:0], ps2_dat};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gap <= '0;
    else if (fall)        gap <= '0;
    else if (!stale)      gap <= gap + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      sh        <= '0;
      byte_cnt  <= '0;
      stat_q    <= '0;
      x_q       <= '0;
      pkt_valid <= 1'b0;
      pkt_err   <= 1'b0;
      btn_left  <= 1'b0;
      btn_right <= 1'b0;
      move_x    <= '0;
      move_y    <= '0;
      ovf_x     <= 1'b0;
      ovf_y     <= 1'b0;
    end else begin
      pkt_valid <= 1'b0;
      pkt_err   <= 1'b0;
      if (fall) begin
        sh      <= {dat, sh[9:1]};
        bit_cnt <= (bit_cnt == LAST_BIT) ? 4'd0 : bit_cnt + 4'd1;
        if (word_done) begin
          if (!word_ok) begin
            pkt_err  <= 1'b1;
            byte_cnt <= 2'd0;
          end else begin
            case (byte_cnt)
              2'd0: if (data[3]) begin
                      stat_q   <= data;
                      byte_cnt <= 2'd1;
                    end
              2'd1: begin
                      x_q      <= data;
                      byte_cnt <= 2'd2;
                    end
              default: begin
                      pkt_valid <= 1'b1;
                      btn_left  <= stat_q[0];
                      btn_right <= stat_q[1];
                      move_x    <= {stat_q[4], x_q};
                      move_y    <= {stat_q[5], data};
                      ovf_x     <= stat_q[6];
                      ovf_y     <= stat_q[7];
                      byte_cnt  <= 2'd0;
                    end
            endcase
          end
        end
      end else if (stale) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/ps2_mouse_decoder_chk.sv
module ps2_mouse_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_valid,
  input logic       pkt_err,
  input logic       btn_left,
  input logic       btn_right,
  input logic [8:0] move_x,
  input logic [8:0] move_y,
  input logic       ovf_x,
  input logic       ovf_y
);
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!pkt_valid && !pkt_err && move_x == 9'd0 && move_y == 9'd0));

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid);

  p_err_excludes_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_valid && pkt_err));

  p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_err |=> !pkt_err);

  p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> $stable({btn_left, btn_right, move_x, move_y, ovf_x, ovf_y}));
endmodule

bind ps2_mouse_decoder ps2_mouse_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_err(pkt_err),
  .btn_left(btn_left), .btn_right(btn_right), .move_x(move_x),
  .move_y(move_y), .ovf_x(ovf_x), .ovf_y(ovf_y)
);

// File: tb/sim_ps2_mouse_decoder.sv
module sim_ps2_mouse_decoder;
  localparam int GAP  = 300;
  localparam int HALF = 15;
  localparam int WGAP = 40;

  logic clk = 1'b0, rst_n = 1'b0, ps2_clk = 1'b1, ps2_dat = 1'b1;
  logic pkt_valid, btn_left, btn_right, ovf_x, ovf_y, pkt_err;
  logic [8:0] move_x, move_y;
  int tests = 0, fails = 0, err_seen = 0, valid_seen = 0, pkts_sent = 0;
  logic [21:0] expq[$];
  logic [21:0] last_exp;

  always #5 clk = ~clk;

  ps2_mouse_decoder #(.GAP_CYCLES(GAP), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ps2_clk(ps2_clk), .ps2_dat(ps2_dat),
    .pkt_valid(pkt_valid), .btn_left(btn_left), .btn_right(btn_right),
    .move_x(move_x), .move_y(move_y), .ovf_x(ovf_x), .ovf_y(ovf_y),
    .pkt_err(pkt_err));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] expect_of(input logic [7:0] s, input logic [7:0] x, input logic [7:0] y);
    return {s[0], s[1], s[6], s[7], s[4], x, s[5], y};
  endfunction

  task automatic check_fields(input logic [21:0] e);
    chk("R3 left", btn_left, e[21]);
    chk("R3 right", btn_right, e[20]);
    chk("R5 ovf_x", ovf_x, e[19]);
    chk("R5 ovf_y", ovf_y, e[18]);
    chk("R4 move_x", move_x, e[17:9]);
    chk("R4 move_y", move_y, e[8:0]);
  endtask

  always @(negedge clk) begin
    if (pkt_err) err_seen++;
    if (pkt_valid) begin
      valid_seen++;
      if (expq.size() == 0) chk("R2 unexpected packet", 1, 0);
      else check_fields(expq.pop_front());
    end
  end

  task automatic send_bits(input logic [10:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      ps2_dat = w[i];
      repeat (HALF) @(negedge clk);
      ps2_clk = 1'b0;
      repeat (HALF) @(negedge clk);
      ps2_clk = 1'b1;
    end
    ps2_dat = 1'b1;
    repeat (WGAP) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] d, input int fault);
    logic [10:0] w;
    w = {1'b1, ~^d, d, 1'b0};
    if (fault == 1) w[9] = ~w[9];
    if (fault == 2) w[0] = 1'b1;
    if (fault == 3) w[10] = 1'b0;
    send_bits(w, 11);
  endtask

  task automatic send_packet(input logic [7:0] s, input logic [7:0] x, input logic [7:0] y);
    last_exp = expect_of(s, x, y);
    expq.push_back(last_exp);
    pkts_sent++;
    send_word(s, 0);
    send_word(x, 0);
    send_word(y, 0);
  endtask

  task automatic idle();
    repeat (GAP + 50) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 valid in reset", pkt_valid, 0);
    chk("R1 err in reset", pkt_err, 0);
    chk("R1 move_x in reset", move_x, 0);
    chk("R1 move_y in reset", move_y, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    send_packet(8'h09, 8'h05, 8'h03);
    idle();
    send_packet(8'h3A, 8'hF0, 8'h80);
    idle();
    send_packet(8'hCB, 8'hFF, 8'h00);
    idle();
    send_packet(8'h18, 8'h00, 8'h7F);
    idle();
    chk("R10 move_x held", move_x, last_exp[17:9]);
    chk("R10 move_y held", move_y, last_exp[8:0]);

    send_word(8'h01, 0);
    send_packet(8'h29, 8'h11, 8'h22);
    idle();
    chk("R6 misaligned byte dropped", int'(expq.size()), 0);
    chk("R6 no error", err_seen, 0);

    send_word(8'h08, 0);
    send_word(8'h10, 0);
    send_word(8'h20, 1);
    idle();
    chk("R7 parity error strobe", err_seen, 1);
    send_packet(8'h0A, 8'h44, 8'h55);
    idle();

    send_word(8'h08, 0);
    send_word(8'h33, 3);
    idle();
    send_word(8'h08, 2);
    idle();
    chk("R8 framing error strobes", err_seen, 3);
    send_packet(8'h39, 8'h81, 8'hFE);
    idle();

    send_word(8'h08, 0);
    send_word(8'h12, 0);
    idle();
    send_packet(8'h08, 8'h06, 8'h07);
    idle();
    send_bits(11'h7F0, 5);
    idle();
    send_packet(8'h0B, 8'h60, 8'h9C);
    idle();
    chk("R9 stale partial packets discarded", int'(expq.size()), 0);
    chk("R2 one valid per packet", valid_seen, pkts_sent);
    chk("R7 no extra errors", err_seen, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule